// File: doc/BRIEF.md
# Camellia Round Coprocessor Engine

This unit holds the 128-bit working state of the Camellia block cipher as two 64-bit halves, left and right. A host processor drives the cipher one primitive at a time. Each 64-bit register write carries a 16-bit selector. Writes to the two state selectors load a half. Writes to one of the three operation selectors supply a 64-bit subkey and fire one action in the same cycle:

- a Feistel round built on the F-function,
- an FL layer applied to the left half,
- an FL-inverse layer applied to the right half.

The host does the rest of the cipher. It expands the key, applies the pre- and post-whitening by XOR on values it reads back, and issues the 18 (or 24) rounds with the FL layers between them. The state halves share their selector addresses with the result/input bank of a neighbouring cipher engine, so the operation selector values must stay fixed. The host reads a half back through a separate read port with a one-cycle latency.

Top module: `cam_round_engine`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both state halves to zero.
- R2: A write with selector `SEL_LEFT` (default 16'h0100) loads `wrData` into the left half, and a write with `SEL_RIGHT` (default 16'h0101) loads the right half. The other half is unchanged.
- R3: A write with selector 16'h3114 treats `wrData` as subkey k. It sets left to old right XOR F(old left, k) and right to old left, in one cycle.
- R4: F(x, k) forms z = x XOR k and splits z into bytes t1..t8, with t1 the most significant byte. The bytes go through substitution variants 1,2,3,4,2,3,4,1 in that order:
  - variant 1 is the Camellia S-box (s(0)=112, s(1)=130);
  - variant 2 is the S-box output rotated left by 1;
  - variant 3 is the S-box output rotated left by 7;
  - variant 4 is the S-box applied to the input rotated left by 1.

  The output bytes, most significant first, are y1=t1^t3^t4^t6^t7^t8, y2=t1^t2^t4^t5^t7^t8, y3=t1^t2^t3^t5^t6^t8, y4=t2^t3^t4^t5^t6^t7, y5=t1^t2^t6^t7^t8, y6=t2^t3^t5^t7^t8, y7=t3^t4^t5^t6^t8 and y8=t1^t4^t5^t6^t7. For example, F(z=0) = 64'h00000000A838E0A8.
- R5: A write with selector 16'h0115 splits left into {x1,x2} and the key into {k1,k2} (32-bit halves, upper first). It computes x2 ^= rotl32(x1&k1,1), then x1 ^= (x2|k2), and stores {x1,x2} in left. Right is unchanged.
- R6: A write with selector 16'h0116 splits right into {y1,y2} and the key into {k1,k2}. It computes y1 ^= (y2|k2), then y2 ^= rotl32(y1&k1,1), and stores {y1,y2} in right. Left is unchanged.
- R7: A write with any other selector leaves both halves unchanged.
- R8: A read request (`rdEn` high, `rdHalf` 0 for left, 1 for right) returns that half on `rdData`, with `rdAck` high, exactly one cycle later. The value returned is the state before any write in the same cycle.
- R9: FL-inverse with the same key undoes FL: a value passed through FL and then through FL-inverse comes back unchanged.
- R10: Driving the 128-bit-key encryption sequence with the correct subkeys gives the published ciphertext 67673138549669730857065648eabe43 for key and plaintext 0123456789abcdeffedcba9876543210.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 16 | Write selector |
| wrData | input | 64 | Write data: half value or subkey |
| rdEn | input | 1 | Read request |
| rdHalf | input | 1 | Half to read: 0 left, 1 right |
| rdData | output | 64 | Read data, one cycle after the request |
| rdAck | output | 1 | Read data valid |

## Verification
Every write, whether a load or an operation, changes the state at the clock edge where `wrEn` is sampled. The earliest read that can see the new state is therefore requested in the following cycle. Read data and `rdAck` are registered, so they appear one edge after the request. The bench drives every input on the falling edge. A driver task queues the expected value at the moment it raises `rdEn`, and a monitor samples `rdAck` and `rdData` on the next falling edge, half a cycle after the data is registered. The monitor also compares `rdAck` with the request it saw at the rising edge, so an early, late or missing acknowledge is reported.

// File: rtl/cam_pkg.sv
package cam_pkg;

  localparam int HALF_W = 64;
  localparam int BYTE_W = 8;
  localparam int LANES  = HALF_W / BYTE_W;
  localparam int WORD_W = HALF_W / 2;
  localparam int SEL_W  = 16;

  // Strobes from the selector decoder to the datapath.
  typedef struct packed {
    logic loadLeft;
    logic loadRight;
    logic doRound;
    logic doFl;
    logic doFlInv;
  } camStrobe_t;

  // Base substitution, kept as four 64-entry quarters picked by the top two bits.
  localparam logic [0:63][7:0] SBOX_Q0 = {
    8'd112, 8'd130, 8'd44,  8'd236, 8'd179, 8'd39,  8'd192, 8'd229,
    8'd228, 8'd133, 8'd87,  8'd53,  8'd234, 8'd12,  8'd174, 8'd65,
    8'd35,  8'd239, 8'd107, 8'd147, 8'd69,  8'd25,  8'd165, 8'd33,
    8'd237, 8'd14,  8'd79,  8'd78,  8'd29,  8'd101, 8'd146, 8'd189,
    8'd134, 8'd184, 8'd175, 8'd143, 8'd124, 8'd235, 8'd31,  8'd206,
    8'd62,  8'd48,  8'd220, 8'd95,  8'd94,  8'd197, 8'd11,  8'd26,
    8'd166, 8'd225, 8'd57,  8'd202, 8'd213, 8'd71,  8'd93,  8'd61,
    8'd217, 8'd1,   8'd90,  8'd214, 8'd81,  8'd86,  8'd108, 8'd77
  };
  localparam logic [0:63][7:0] SBOX_Q1 = {
    8'd139, 8'd13,  8'd154, 8'd102, 8'd251, 8'd204, 8'd176, 8'd45,
    8'd116, 8'd18,  8'd43,  8'd32,  8'd240, 8'd177, 8'd132, 8'd153,
    8'd223, 8'd76,  8'd203, 8'd194, 8'd52,  8'd126, 8'd118, 8'd5,
    8'd109, 8'd183, 8'd169, 8'd49,  8'd209, 8'd23,  8'd4,   8'd215,
    8'd20,  8'd88,  8'd58,  8'd97,  8'd222, 8'd27,  8'd17,  8'd28,
    8'd50,  8'd15,  8'd156, 8'd22,  8'd83,  8'd24,  8'd242, 8'd34,
    8'd254, 8'd68,  8'd207, 8'd178, 8'd195, 8'd181, 8'd122, 8'd145,
    8'd36,  8'd8,   8'd232, 8'd168, 8'd96,  8'd252, 8'd105, 8'd80
  };
  localparam logic [0:63][7:0] SBOX_Q2 = {
    8'd170, 8'd208, 8'd160, 8'd125, 8'd161, 8'd137, 8'd98,  8'd151,
    8'd84,  8'd91,  8'd30,  8'd149, 8'd224, 8'd255, 8'd100, 8'd210,
    8'd16,  8'd196, 8'd0,   8'd72,  8'd163, 8'd247, 8'd117, 8'd219,
    8'd138, 8'd3,   8'd230, 8'd218, 8'd9,   8'd63,  8'd221, 8'd148,
    8'd135, 8'd92,  8'd131, 8'd2,   8'd205, 8'd74,  8'd144, 8'd51,
    8'd115, 8'd103, 8'd246, 8'd243, 8'd157, 8'd127, 8'd191, 8'd226,
    8'd82,  8'd155, 8'd216, 8'd38,  8'd200, 8'd55,  8'd198, 8'd59,
    8'd129, 8'd150, 8'd111, 8'd75,  8'd19,  8'd190, 8'd99,  8'd46
  };
  localparam logic [0:63][7:0] SBOX_Q3 = {
    8'd233, 8'd121, 8'd167, 8'd140, 8'd159, 8'd110, 8'd188, 8'd142,
    8'd41,  8'd245, 8'd249, 8'd182, 8'd47,  8'd253, 8'd180, 8'd89,
    8'd120, 8'd152, 8'd6,   8'd106, 8'd231, 8'd70,  8'd113, 8'd186,
    8'd212, 8'd37,  8'd171, 8'd66,  8'd136, 8'd162, 8'd141, 8'd250,
    8'd114, 8'd7,   8'd185, 8'd85,  8'd248, 8'd238, 8'd172, 8'd10,
    8'd54,  8'd73,  8'd42,  8'd104, 8'd60,  8'd56,  8'd241, 8'd164,
    8'd64,  8'd40,  8'd211, 8'd123, 8'd187, 8'd201, 8'd67,  8'd193,
    8'd21,  8'd227, 8'd173, 8'd244, 8'd119, 8'd199, 8'd128, 8'd158
  };

  function automatic logic [BYTE_W-1:0] sboxBase(input logic [BYTE_W-1:0] x);
    logic [BYTE_W-1:0] r;
    unique case (x[7:6])
      2'd0: r = SBOX_Q0[x[5:0]];
      2'd1: r = SBOX_Q1[x[5:0]];
      2'd2: r = SBOX_Q2[x[5:0]];
      default: r = SBOX_Q3[x[5:0]];
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] v, input int n);
    return BYTE_W'((v << n) | (v >> (BYTE_W - n)));
  endfunction

  function automatic logic [WORD_W-1:0] rotl32by1(input logic [WORD_W-1:0] v);
    return {v[WORD_W-2:0], v[WORD_W-1]};
  endfunction

  // Substitution variant used by byte lane j (lane 0 is the most significant byte).
  function automatic int laneVariant(input int j);
    int v;
    case (j)
      0, 7:    v = 1;
      1, 4:    v = 2;
      2, 5:    v = 3;
      default: v = 4;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cam_sub_lane.sv
module cam_sub_lane
  import cam_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  generate
    if (VARIANT == 2) begin : g_rot1
      assign dout = rotl8(sboxBase(din), 1);
    end else if (VARIANT == 3) begin : g_rot7
      assign dout = rotl8(sboxBase(din), 7);
    end else if (VARIANT == 4) begin : g_prerot
      assign dout = sboxBase(rotl8(din, 1));
    end else begin : g_base
      assign dout = sboxBase(din);
    end
  endgenerate

endmodule

// File: rtl/cam_ffunc.sv
module cam_ffunc
  import cam_pkg::*;
(
  input  logic [HALF_W-1:0] din,
  input  logic [HALF_W-1:0] key,
  output logic [HALF_W-1:0] dout
);

  logic [HALF_W-1:0] mixed;
  logic [BYTE_W-1:0] t [LANES];

  assign mixed = din ^ key;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    cam_sub_lane #(.VARIANT(laneVariant(j))) u_lane (
      .din (mixed[HALF_W-1-BYTE_W*j -: BYTE_W]),
      .dout(t[j])
    );
  end

  // Byte diffusion; t[0] is the most significant lane.
  always_comb begin
    dout[63:56] = t[0] ^ t[2] ^ t[3] ^ t[5] ^ t[6] ^ t[7];
    dout[55:48] = t[0] ^ t[1] ^ t[3] ^ t[4] ^ t[6] ^ t[7];
    dout[47:40] = t[0] ^ t[1] ^ t[2] ^ t[4] ^ t[5] ^ t[7];
    dout[39:32] = t[1] ^ t[2] ^ t[3] ^ t[4] ^ t[5] ^ t[6];
    dout[31:24] = t[0] ^ t[1] ^ t[5] ^ t[6] ^ t[7];
    dout[23:16] = t[1] ^ t[2] ^ t[4] ^ t[6] ^ t[7];
    dout[15:8]  = t[2] ^ t[3] ^ t[4] ^ t[5] ^ t[7];
    dout[7:0]   = t[0] ^ t[3] ^ t[4] ^ t[5] ^ t[6];
  end

endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_LEFT  = 16'h0100,
  parameter logic [SEL_W-1:0] SEL_RIGHT = 16'h0101,
  parameter logic [SEL_W-1:0] SEL_ROUND = 16'h3114,
  parameter logic [SEL_W-1:0] SEL_FL    = 16'h0115,
  parameter logic [SEL_W-1:0] SEL_FLINV = 16'h0116
) (
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  output camStrobe_t       strb
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (wrSel == SEL_LEFT)  strb.loadLeft  = 1'b1;
      if (wrSel == SEL_RIGHT) strb.loadRight = 1'b1;
      if (wrSel == SEL_ROUND) strb.doRound   = 1'b1;
      if (wrSel == SEL_FL)    strb.doFl      = 1'b1;
      if (wrSel == SEL_FLINV) strb.doFlInv   = 1'b1;
    end
  end

endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  camStrobe_t        strb,
  input  logic [HALF_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdHalf,
  output logic [HALF_W-1:0] rdData,
  output logic              rdAck
);

  logic [HALF_W-1:0] stateL, stateR;
  logic [HALF_W-1:0] nextL, nextR;
  logic [HALF_W-1:0] fOut, flOut, flInvOut;

  cam_ffunc u_ffunc (
    .din (stateL),
    .key (wrData),
    .dout(fOut)
  );

  // FL on the left half.
  logic [WORD_W-1:0] flX1, flX2;
  always_comb begin
    flX2  = stateL[WORD_W-1:0] ^ rotl32by1(stateL[HALF_W-1:WORD_W] & wrData[HALF_W-1:WORD_W]);
    flX1  = stateL[HALF_W-1:WORD_W] ^ (flX2 | wrData[WORD_W-1:0]);
    flOut = {flX1, flX2};
  end

  // FL-inverse on the right half.
  logic [WORD_W-1:0] fiY1, fiY2;
  always_comb begin
    fiY1     = stateR[HALF_W-1:WORD_W] ^ (stateR[WORD_W-1:0] | wrData[WORD_W-1:0]);
    fiY2     = stateR[WORD_W-1:0] ^ rotl32by1(fiY1 & wrData[HALF_W-1:WORD_W]);
    flInvOut = {fiY1, fiY2};
  end

  always_comb begin
    nextL = stateL;
    nextR = stateR;
    if (strb.loadLeft)  nextL = wrData;
    if (strb.loadRight) nextR = wrData;
    if (strb.doRound) begin
      nextL = stateR ^ fOut;
      nextR = stateL;
    end
    if (strb.doFl)    nextL = flOut;
    if (strb.doFlInv) nextR = flInvOut;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateL <= '0;
      stateR <= '0;
    end else begin
      stateL <= nextL;
      stateR <= nextR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdAck  <= 1'b0;
      rdData <= '0;
    end else begin
      rdAck <= rdEn;
      if (rdEn) rdData <= rdHalf ? stateR : stateL;
    end
  end

  // R2
  p_load_left_r2: assert property (@(posedge clk) disable iff (rst)
    strb.loadLeft |=> stateL == $past(wrData));
  // R3
  p_round_step_r3: assert property (@(posedge clk) disable iff (rst)
    strb.doRound |=> (stateL == $past(stateR ^ fOut)) && (stateR == $past(stateL)));
  // R5
  p_fl_keeps_right_r5: assert property (@(posedge clk) disable iff (rst)
    strb.doFl |=> stateR == $past(stateR));
  // R6
  p_flinv_keeps_left_r6: assert property (@(posedge clk) disable iff (rst)
    strb.doFlInv |=> stateL == $past(stateL));
  // R7
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> (stateL == $past(stateL)) && (stateR == $past(stateR)));
  // R8
  p_read_ack_r8: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdAck);
  p_read_data_r8: assert property (@(posedge clk) disable iff (rst)
    rdAck |-> rdData == ($past(rdHalf) ? $past(stateR) : $past(stateL)));

endmodule

// File: rtl/cam_round_engine.sv
module cam_round_engine
  import cam_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_LEFT  = 16'h0100,
  parameter logic [SEL_W-1:0] SEL_RIGHT = 16'h0101,
  parameter logic [SEL_W-1:0] SEL_ROUND = 16'h3114,
  parameter logic [SEL_W-1:0] SEL_FL    = 16'h0115,
  parameter logic [SEL_W-1:0] SEL_FLINV = 16'h0116
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [HALF_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdHalf,
  output logic [HALF_W-1:0] rdData,
  output logic              rdAck
);

  camStrobe_t strb;

  cam_ctrl #(
    .SEL_LEFT (SEL_LEFT),
    .SEL_RIGHT(SEL_RIGHT),
    .SEL_ROUND(SEL_ROUND),
    .SEL_FL   (SEL_FL),
    .SEL_FLINV(SEL_FLINV)
  ) u_ctrl (
    .wrEn (wrEn),
    .wrSel(wrSel),
    .strb (strb)
  );

  cam_datapath u_dp (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .wrData(wrData),
    .rdEn  (rdEn),
    .rdHalf(rdHalf),
    .rdData(rdData),
    .rdAck (rdAck)
  );

endmodule

// File: tb/test_cam_round_engine.sv
`timescale 1ns/1ps
module test_cam_round_engine;

  localparam logic [15:0] S_LEFT  = 16'h0100;
  localparam logic [15:0] S_RIGHT = 16'h0101;
  localparam logic [15:0] S_ROUND = 16'h3114;
  localparam logic [15:0] S_FL    = 16'h0115;
  localparam logic [15:0] S_FLINV = 16'h0116;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] wrSel = '0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic        rdHalf = 1'b0;
  logic [63:0] rdData;
  logic        rdAck;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cam_round_engine i_cam_round_engine (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdHalf(rdHalf), .rdData(rdData), .rdAck(rdAck)
  );

  typedef struct {
    logic [63:0] exp;
    bit          chk;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [63:0] lastRead;
  logic        reqAtEdge = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: remember whether a request was sampled at the rising edge.
  always @(posedge clk) reqAtEdge <= rdEn && !rst;

  always @(negedge clk) begin
    if (!rst) begin
      if (reqAtEdge || rdAck)
        check(rdAck == reqAtEdge, "R8 ack one cycle after request", 64'(rdAck), 64'(reqAtEdge));
      if (rdAck && sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        lastRead = rdData;
        if (it.chk) check(rdData === it.exp, it.tag, rdData, it.exp);
      end
    end
  end

  task automatic wr(input logic [15:0] s, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic h, input logic [63:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rdEn = 1'b1; rdHalf = h;
    it.exp = e; it.chk = 1'b1; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
    #1;
  endtask

  task automatic readRaw(input logic h, output logic [63:0] v);
    item_t it;
    @(negedge clk);
    rdEn = 1'b1; rdHalf = h;
    it.exp = '0; it.chk = 1'b0; it.tag = "raw";
    sb.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
    #1;
    v = lastRead;
  endtask

  task automatic load(input logic [63:0] l, input logic [63:0] r);
    wr(S_LEFT, l);
    wr(S_RIGHT, r);
  endtask

  function automatic logic [127:0] rotl128(input logic [127:0] x, input int n);
    return (x << n) | (x >> (128 - n));
  endfunction

  // Watchdog
  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] kl, ka, ct;
    logic [63:0]  d1, d2, kaL, kaR;
    logic [63:0]  rk [1:18];
    logic [63:0]  ke [1:4];
    logic [63:0]  kw3, kw4;
    logic [127:0] kl15, ka15, ka30, kl45, ka45, kl60, ka60, kl77, kl94, ka94, kl111, ka111;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rdCheck(1'b0, 64'h0, "R1 left after reset");
    rdCheck(1'b1, 64'h0, "R1 right after reset");

    // R2: loads touch one half only
    wr(S_LEFT, 64'h1122334455667788);
    rdCheck(1'b0, 64'h1122334455667788, "R2 left load");
    rdCheck(1'b1, 64'h0, "R2 right untouched by left load");
    wr(S_RIGHT, 64'h99AABBCCDDEEFF00);
    rdCheck(1'b1, 64'h99AABBCCDDEEFF00, "R2 right load");
    rdCheck(1'b0, 64'h1122334455667788, "R2 left untouched by right load");

    // R7: unlisted selectors ignored
    wr(16'h3115, 64'hDEADBEEFDEADBEEF);
    wr(16'h0114, 64'hFFFFFFFFFFFFFFFF);
    wr(16'h0000, 64'h0123456789ABCDEF);
    wr(16'h1114, 64'h0F0F0F0F0F0F0F0F);
    rdCheck(1'b0, 64'h1122334455667788, "R7 left after unknown selectors");
    rdCheck(1'b1, 64'h99AABBCCDDEEFF00, "R7 right after unknown selectors");

    // R8: read in the same cycle as a write returns the old value
    @(negedge clk);
    wrEn = 1'b1; wrSel = S_LEFT; wrData = 64'hCAFEF00DCAFEF00D;
    rdEn = 1'b1; rdHalf = 1'b0;
    begin
      item_t it;
      it.exp = 64'h1122334455667788; it.chk = 1'b1; it.tag = "R8 read sees pre-write value";
      sb.push_back(it);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    rdCheck(1'b0, 64'hCAFEF00DCAFEF00D, "R8 read after write");

    // R3: round with key equal to left, F(0) = 00000000A838E0A8
    load(64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
    wr(S_ROUND, 64'h0123456789ABCDEF);
    rdCheck(1'b0, 64'hFEDCBA98DE6CD2B8, "R3 round new left");
    rdCheck(1'b1, 64'h0123456789ABCDEF, "R3 round new right is old left");

    // R4: single-byte inputs probe each substitution variant
    load(64'h0100000000000000, 64'h0);
    wr(S_ROUND, 64'h0);
    rdCheck(1'b0, 64'hF2F2F2005A38E05A, "R4 lane1 variant1");
    load(64'h0001000000000000, 64'h0);
    wr(S_ROUND, 64'h0);
    rdCheck(1'b0, 64'h00E5E5E54DDDE0A8, "R4 lane2 variant2");
    load(64'h0000010000000000, 64'h0);
    wr(S_ROUND, 64'h0);
    rdCheck(1'b0, 64'h79007979A84199A8, "R4 lane3 variant3");
    load(64'h0000008000000000, 64'h0);
    wr(S_ROUND, 64'h0);
    rdCheck(1'b0, 64'hF2F200F2A838125A, "R4 lane4 variant4");

    // R5: FL on left, right untouched
    load(64'h8000000100000000, 64'h5555AAAA5555AAAA);
    wr(S_FL, 64'hFFFFFFFF00000000);
    rdCheck(1'b0, 64'h8000000200000003, "R5 FL left");
    rdCheck(1'b1, 64'h5555AAAA5555AAAA, "R5 FL right untouched");
    load(64'h12345678F0F0F0F0, 64'h0);
    wr(S_FL, 64'h0);
    rdCheck(1'b0, 64'hE2C4A688F0F0F0F0, "R5 FL zero key");

    // R6 and R9: FL-inverse on right undoes FL
    load(64'h3333333333333333, 64'h8000000200000003);
    wr(S_FLINV, 64'hFFFFFFFF00000000);
    rdCheck(1'b1, 64'h8000000100000000, "R9 FLINV restores FL input");
    rdCheck(1'b0, 64'h3333333333333333, "R6 FLINV left untouched");
    load(64'h0, 64'hE2C4A688F0F0F0F0);
    wr(S_FLINV, 64'h0);
    rdCheck(1'b1, 64'h12345678F0F0F0F0, "R6 FLINV zero key");

    // R10: full 128-bit-key encryption. Key schedule rounds use the engine itself.
    kl = 128'h0123456789abcdeffedcba9876543210;
    ct = 128'h67673138549669730857065648eabe43;
    load(kl[127:64], kl[63:0]);
    wr(S_ROUND, 64'hA09E667F3BCC908B);
    wr(S_ROUND, 64'hB67AE8584CAA73B2);
    readRaw(1'b0, d1);
    readRaw(1'b1, d2);
    load(d1 ^ kl[127:64], d2 ^ kl[63:0]);
    wr(S_ROUND, 64'hC6EF372FE94F82BE);
    wr(S_ROUND, 64'h54FF53A5F1D36F1C);
    readRaw(1'b0, kaL);
    readRaw(1'b1, kaR);
    ka = {kaL, kaR};

    kl15 = rotl128(kl, 15);  ka15 = rotl128(ka, 15);  ka30 = rotl128(ka, 30);
    kl45 = rotl128(kl, 45);  ka45 = rotl128(ka, 45);  kl60 = rotl128(kl, 60);
    ka60 = rotl128(ka, 60);  kl77 = rotl128(kl, 77);  kl94 = rotl128(kl, 94);
    ka94 = rotl128(ka, 94);  kl111 = rotl128(kl, 111); ka111 = rotl128(ka, 111);
    rk[1]  = ka[127:64];    rk[2]  = ka[63:0];
    rk[3]  = kl15[127:64];  rk[4]  = kl15[63:0];
    rk[5]  = ka15[127:64];  rk[6]  = ka15[63:0];
    rk[7]  = kl45[127:64];  rk[8]  = kl45[63:0];
    rk[9]  = ka45[127:64];  rk[10] = kl60[63:0];
    rk[11] = ka60[127:64];  rk[12] = ka60[63:0];
    rk[13] = kl94[127:64];  rk[14] = kl94[63:0];
    rk[15] = ka94[127:64];  rk[16] = ka94[63:0];
    rk[17] = kl111[127:64]; rk[18] = kl111[63:0];
    ke[1] = ka30[127:64];   ke[2] = ka30[63:0];
    ke[3] = kl77[127:64];   ke[4] = kl77[63:0];
    kw3 = ka111[127:64];    kw4 = ka111[63:0];

    // Pre-whitening: plaintext equals the key, so the state starts at zero.
    load(kl[127:64] ^ kl[127:64], kl[63:0] ^ kl[63:0]);
    for (int r = 1; r <= 18; r++) begin
      wr(S_ROUND, rk[r]);
      if (r == 6 || r == 12) begin
        wr(S_FL, ke[r / 3 - 1]);
        wr(S_FLINV, ke[r / 3]);
      end
    end
    rdCheck(1'b1, ct[127:64] ^ kw3, "R10 ciphertext upper half");
    rdCheck(1'b0, ct[63:0] ^ kw4, "R10 ciphertext lower half");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R8 every request acknowledged", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule